// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier

This block multiplies two elements of the binary extension field GF(2^m). Both elements are in polynomial basis, and the modulus is a fixed low-weight polynomial. The multiplier operand is consumed one digit per clock cycle, starting from its most significant end. In each digit step the running sum is shifted up by one digit width, the partial product of the full multiplicand and the current digit is XORed into it, and the result is folded back below degree m. Because the modulus has only a few low-order terms, that fold is a fixed XOR network.

A one-cycle start pulse launches a multiplication, and both operands are sampled on that edge. With the default configuration the field is m = 163 and there are four digits of 41 bits, so the multiplier operand is zero-padded to 164 bits. An optional pipeline register sits between the partial-product array and the accumulate-and-fold stage, which adds one cycle of latency. The reduced product appears on a held output register together with a single-cycle done pulse.

Top module: `bf_digit_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done_o`, `busy_o` and `prod_o` are all zero.
- R2: On completion, `prod_o` holds a·b mod f(x), where f(x) = x^163 + x^7 + x^6 + x^3 + 1. Bit i of every operand and of the result is the coefficient of x^i, and the part of f below x^163 is the constant 163'hC9.
- R3: `done_o` goes high for exactly one cycle. With the default pipelined configuration it rises on the fifth rising edge after the edge that sampled `start_i`, i.e. four digit cycles plus one pipeline cycle.
- R4: A start seen while idle is accepted. `busy_o` is high from the edge after acceptance until the edge on which `done_o` rises, and `busy_o` and `done_o` are never high together.
- R5: A start pulse that arrives while `busy_o` is high is ignored: neither the result nor the completion cycle changes.
- R6: Changes on `a_i` and `b_i` after the accepting edge have no effect on the running multiplication.
- R7: `prod_o` changes only on the edge that raises `done_o` (or at reset) and holds its value in every other cycle.
- R8: Multiplying by 0 yields 0, and multiplying by 1 returns the other operand unchanged. This holds with either operand in either position.
- R9: A start presented in the cycle where `done_o` is high is accepted. The product just delivered can be used as both operands of that next multiplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch pulse; sampled only while idle |
| a_i | input | M (163) | Multiplicand, polynomial basis |
| b_i | input | M (163) | Multiplier, consumed most significant digit first |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse: `prod_o` carries a new result |
| prod_o | output | M (163) | Fully reduced product, held between results |

## Verification
The hardest situation to reach from the ports is a stray start pulse or an operand change that lands in the middle of the digit sequence. Either one would corrupt the result only if the sampled operands or the digit counters were disturbed. The stimulus therefore pulses `start_i` with different operands at a fixed digit cycle, and in another run toggles `a_i` and `b_i` on every busy cycle. Both runs compare the result and the completion cycle against an undisturbed run.

The fold network's worst case comes from x^162 times x^162 and from all-ones operands, where every high bit of the shifted sum is set. A back-to-back run feeds the delivered product straight back in as both operands on the cycle `done_o` is high.

// File: rtl/bf_mul_pkg.sv
package bf_mul_pkg;

   // Default field degree and the part of the modulus below x^M
   localparam int unsigned BF_M_DEF      = 163;
   localparam int unsigned BF_DIGITS_DEF = 4;
   localparam logic [BF_M_DEF-1:0] BF_TAIL_DEF = BF_M_DEF'('hC9);

   // Ceiling division used to derive the digit width
   function automatic int unsigned bf_ceil_div(input int unsigned n, input int unsigned d);
      return (n + d - 1) / d;
   endfunction

endpackage

// File: rtl/bf_pp_gen.sv
// Carry-less product of an M-bit multiplicand and a W-bit digit.
module bf_pp_gen #(
   parameter int unsigned M = 163,
   parameter int unsigned W = 41,
   localparam int unsigned PW = M + W - 1
) (
   input  logic [M-1:0]  mcand_i,
   input  logic [W-1:0]  digit_i,
   output logic [PW-1:0] pp_o
);

   logic [PW-1:0] row [W];

   for (genvar j = 0; j < W; j++) begin : g_row
      assign row[j] = digit_i[j] ? (PW'(mcand_i) << j) : '0;
   end

   always_comb begin
      pp_o = '0;
      for (int j = 0; j < W; j++) begin
         pp_o = pp_o ^ row[j];
      end
   end

endmodule

// File: rtl/bf_fold_reduce.sv
// Folds an (M+W)-bit polynomial back below degree M in a single pass.
// Valid because the tail of the modulus has degree at most M-W.
module bf_fold_reduce #(
   parameter int unsigned M = 163,
   parameter int unsigned W = 41,
   parameter logic [M-1:0] TAIL = M'('hC9)
) (
   input  logic [M+W-1:0] wide_i,
   output logic [M-1:0]   red_o
);

   always_comb begin
      red_o = wide_i[M-1:0];
      for (int i = 0; i < W; i++) begin
         if (wide_i[M+i]) begin
            red_o = red_o ^ (TAIL << i);
         end
      end
   end

endmodule

// File: rtl/bf_mul_seq.sv
// Sequencer: accepts starts, issues digits, steps the accumulator,
// and raises the completion pulse.
module bf_mul_seq #(
   parameter int unsigned DIGITS = 4,
   parameter bit          PIPE   = 1'b1,
   localparam int unsigned CW = $clog2(DIGITS + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic load_o,
   output logic issue_o,
   output logic step_o,
   output logic last_o,
   output logic done_o
);

   logic          busy_q;
   logic [CW-1:0] issue_cnt_q;
   logic [CW-1:0] step_cnt_q;
   logic          done_q;

   assign load_o  = start_i && !busy_q;
   assign issue_o = busy_q && (issue_cnt_q != CW'(DIGITS));
   assign last_o  = (step_cnt_q == CW'(DIGITS - 1));

   if (PIPE) begin : g_piped
      logic vld_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) vld_q <= 1'b0;
         else         vld_q <= issue_o;
      end
      assign step_o = vld_q;
   end else begin : g_flat
      assign step_o = issue_o;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q      <= 1'b0;
         issue_cnt_q <= '0;
         step_cnt_q  <= '0;
         done_q      <= 1'b0;
      end else begin
         done_q <= step_o && last_o;
         if (load_o) begin
            busy_q      <= 1'b1;
            issue_cnt_q <= '0;
            step_cnt_q  <= '0;
         end else begin
            if (issue_o) issue_cnt_q <= issue_cnt_q + 1'b1;
            if (step_o)  step_cnt_q  <= step_cnt_q + 1'b1;
            if (step_o && last_o) busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;

endmodule

// File: rtl/bf_digit_mult.sv
module bf_digit_mult
   import bf_mul_pkg::*;
#(
   parameter int unsigned  M      = BF_M_DEF,
   parameter int unsigned  DIGITS = BF_DIGITS_DEF,
   parameter logic [M-1:0] TAIL   = M'(BF_TAIL_DEF),
   parameter bit           PIPE   = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [M-1:0] a_i,
   input  logic [M-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [M-1:0] prod_o
);

   localparam int unsigned W    = bf_ceil_div(M, DIGITS);
   localparam int unsigned BPAD = W * DIGITS;
   localparam int unsigned PW   = M + W - 1;

   // Elaboration-time parameter checks
   if (DIGITS < 1) begin : g_chk_digits
      $error("bf_digit_mult: DIGITS must be at least 1");
   end
   if (W >= M) begin : g_chk_width
      $error("bf_digit_mult: digit width must be below the field degree");
   end
   if (TAIL[0] != 1'b1) begin : g_chk_const
      $error("bf_digit_mult: modulus needs a constant term");
   end
   if ((TAIL >> (M - W)) != '0) begin : g_chk_fold
      $error("bf_digit_mult: modulus tail too high for a one-pass fold");
   end

   logic load, issue, step, last;

   bf_mul_seq #(
      .DIGITS (DIGITS),
      .PIPE   (PIPE)
   ) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .busy_o  (busy_o),
      .load_o  (load),
      .issue_o (issue),
      .step_o  (step),
      .last_o  (last),
      .done_o  (done_o)
   );

   logic [M-1:0]    a_q;
   logic [BPAD-1:0] b_q;
   logic [M-1:0]    acc_q;
   logic [M-1:0]    res_q;
   logic [W-1:0]    digit;
   logic [PW-1:0]   pp_comb;
   logic [PW-1:0]   pp_use;
   logic [M+W-1:0]  wide;
   logic [M-1:0]    acc_nxt;

   assign digit = b_q[BPAD-1 -: W];

   bf_pp_gen #(
      .M (M),
      .W (W)
   ) u_pp (
      .mcand_i (a_q),
      .digit_i (digit),
      .pp_o    (pp_comb)
   );

   if (PIPE) begin : g_pp_reg
      logic [PW-1:0] pp_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)    pp_q <= '0;
         else if (issue) pp_q <= pp_comb;
      end
      assign pp_use = pp_q;
   end else begin : g_pp_wire
      assign pp_use = pp_comb;
   end

   assign wide = {acc_q, {W{1'b0}}} ^ {1'b0, pp_use};

   bf_fold_reduce #(
      .M    (M),
      .W    (W),
      .TAIL (TAIL)
   ) u_fold (
      .wide_i (wide),
      .red_o  (acc_nxt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         a_q   <= '0;
         b_q   <= '0;
         acc_q <= '0;
         res_q <= '0;
      end else begin
         if (load) begin
            a_q   <= a_i;
            b_q   <= BPAD'(b_i);
            acc_q <= '0;
         end else begin
            if (issue) b_q   <= b_q << W;
            if (step)  acc_q <= acc_nxt;
         end
         if (step && last) res_q <= acc_nxt;
      end
   end

   assign prod_o = res_q;

endmodule

// File: rtl/bf_digit_mult_chk.sv
module bf_digit_mult_chk #(
   parameter int unsigned M   = 163,
   parameter int unsigned LAT = 5
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [M-1:0] prod_o
);

   int unsigned busy_len_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     busy_len_q <= 0;
      else if (busy_o) busy_len_q <= busy_len_q + 1;
      else             busy_len_q <= 0;
   end

   // R3
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R4
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R4
   start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o);

   // R5
   busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (busy_len_q == LAT && done_o));

   // R7
   prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(prod_o));

endmodule

bind bf_digit_mult bf_digit_mult_chk #(
   .M   (M),
   .LAT (DIGITS + 32'(PIPE))
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .prod_o  (prod_o)
);

// File: tb/bf_digit_mult_bench.sv
`timescale 1ns/1ps
module bf_digit_mult_bench;

   localparam int unsigned M   = 163;
   localparam int          LAT = 5;
   localparam logic [M-1:0] TAILR = M'('hC9);
   localparam logic [M-1:0] ONES = {M{1'b1}};
   localparam logic [M-1:0] X162 = M'(1) << 162;
   localparam logic [M-1:0] ALT5 = {1'b1, {81{2'b01}}};
   localparam logic [M-1:0] ALTA = {1'b0, {81{2'b10}}};
   localparam logic [M-1:0] K1 = M'('h1234_5678_9ABC_DEF0_1357_9BDF_0246_8ACE_1122_3344);
   localparam logic [M-1:0] K2 = M'('hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978_8796_A5B4);
   localparam int NV = 12;

   // Stimulus table; expected results come from the bit-serial reference
   localparam logic [M-1:0] TA [NV] = '{
      M'(0), M'(1), K1, X162, ONES, X162, ALT5, M'(1) << 81, K1, ONES, TAILR, X162 };
   localparam logic [M-1:0] TB [NV] = '{
      K2, K2, M'(1), X162, ONES, M'(2), ALTA, M'(1) << 81, K2, M'(0), M'(1) << 100, ONES };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [M-1:0] a_in = '0;
   logic [M-1:0] b_in = '0;
   logic         busy, done;
   logic [M-1:0] prod;

   int checks = 0;
   int fails  = 0;
   logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

   always #4 clk = ~clk;

   bf_digit_mult u_bf_digit_mult (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .start_i (start),
      .a_i     (a_in),
      .b_i     (b_in),
      .busy_o  (busy),
      .done_o  (done),
      .prod_o  (prod)
   );

   function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [M-1:0] p = '0;
      for (int i = M - 1; i >= 0; i--) begin
         logic top = p[M-1];
         p = p << 1;
         if (top)  p = p ^ TAILR;
         if (b[i]) p = p ^ a;
      end
      return p;
   endfunction

   task automatic rnd64(output logic [63:0] v);
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
      v  = rs;
   endtask

   task automatic rnd_elem(output logic [M-1:0] v);
      logic [63:0] w0, w1, w2;
      rnd64(w0); rnd64(w1); rnd64(w2);
      v = {w2[34:0], w1, w0};
   endtask

   task automatic chk_val(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // mode 0: plain, 1: extra start while busy, 2: operands toggled while busy
   task automatic run_mul(input logic [M-1:0] a, input logic [M-1:0] b, input int mode,
                          output logic [M-1:0] res, output int lat, output int busy_ok);
      logic [M-1:0] tmp;
      a_in = a; b_in = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat = 0; busy_ok = busy ? 1 : 0;
      while (lat < 40) begin
         if (mode == 1 && lat == 2) begin
            start = 1'b1; a_in = ~a; b_in = b ^ M'(1);
         end else begin
            start = 1'b0;
         end
         if (mode == 2) begin
            rnd_elem(tmp); a_in = tmp;
            rnd_elem(tmp); b_in = tmp;
         end
         @(negedge clk);
         lat++;
         if (done) break;
         if (!busy) busy_ok = 0;
      end
      if (busy) busy_ok = 0;
      start = 1'b0;
      res = prod;
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [M-1:0] r, ra, rb, held;
      int lat, bok;

      repeat (3) @(negedge clk);
      // R1: outputs clear during reset
      chk_int("R1 done in reset", int'(done), 0);
      chk_int("R1 busy in reset", int'(busy), 0);
      chk_val("R1 prod in reset", prod, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_int("R1 done after reset", int'(done), 0);
      chk_val("R1 prod after reset", prod, '0);

      // Table walk: R2 value, R3 latency, R4 busy window, R8 zero/one cases
      for (int i = 0; i < NV; i++) begin
         run_mul(TA[i], TB[i], 0, r, lat, bok);
         chk_val((i < 2 || i == 9) ? "R8 table" : "R2 table", r, ref_mul(TA[i], TB[i]));
         chk_int("R3 latency", lat, LAT);
         chk_int("R4 busy window", bok, 1);
         @(negedge clk);
         chk_int("R3 single-cycle done", int'(done), 0);
      end

      // R8: identity and zero with operands swapped
      run_mul(K2, M'(1), 0, r, lat, bok);
      chk_val("R8 times one", r, K2);
      run_mul(K1, M'(0), 0, r, lat, bok);
      chk_val("R8 times zero", r, M'(0));

      // R2: random operands
      for (int i = 0; i < 20; i++) begin
         rnd_elem(ra); rnd_elem(rb);
         run_mul(ra, rb, 0, r, lat, bok);
         chk_val("R2 random", r, ref_mul(ra, rb));
      end

      // R5: start pulse mid-computation is ignored
      rnd_elem(ra); rnd_elem(rb);
      run_mul(ra, rb, 1, r, lat, bok);
      chk_val("R5 restart ignored value", r, ref_mul(ra, rb));
      chk_int("R5 restart ignored timing", lat, LAT);

      // R6: operand inputs toggled while busy
      rnd_elem(ra); rnd_elem(rb);
      run_mul(ra, rb, 2, r, lat, bok);
      chk_val("R6 operands sampled at start", r, ref_mul(ra, rb));

      // R9: back-to-back, previous product squared, start in the done cycle
      chk_int("R9 done before restart", int'(done), 1);
      held = r;
      run_mul(held, held, 0, r, lat, bok);
      chk_val("R9 back-to-back", r, ref_mul(held, held));
      chk_int("R9 latency", lat, LAT);

      // R7: product holds while idle with changing inputs
      held = prod;
      for (int i = 0; i < 6; i++) begin
         rnd_elem(ra); a_in = ra; b_in = ~ra;
         @(negedge clk);
         chk_val("R7 hold while idle", prod, held);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule